// File: doc/BRIEF.md
# PLL Frequency Lock Detector

This block decides whether a phase-locked loop is running at its intended frequency. It counts feedback clock edges over a window measured in reference clock edges and compares the two counts. Both clocks arrive as single-cycle tick pulses that are already synchronized into one fast system clock. The block does not use one fixed window. While unlocked it uses a short window of `N_TIGHT` reference ticks. Once lock is declared it switches to a longer window of `N_TIGHT + K_EXTRA` ticks. This gives it hysteresis: a loop that only just passed the acquisition test is not dropped by one borderline window.

The block drives a `lock` level and two one-cycle event pulses, one for lock gained and one for lock lost. A `force_unlock` input lets the logic that changes the feedback divider drop lock at once and restart acquisition from a fresh short window.

Top module: `pll_lock_detector`

## Requirements
- R1: After reset, `lock`, `lock_acq` and `lock_lost` are 0 and the detector uses the short window of `N_TIGHT` reference ticks.
- R2: While unlocked, a window closes in the cycle of its `N_TIGHT`-th reference tick. If exactly `N_TIGHT` feedback ticks fell in that window, counting a feedback tick in the closing cycle, then `lock` is 1 from the next cycle, and `lock_acq` is 1 for exactly that one cycle.
- R3: While unlocked, a window that closes with any other feedback count leaves `lock` at 0 with no pulse, and a new short window starts on the next cycle.
- R4: While locked, a window spans `N_TIGHT + K_EXTRA` reference ticks. If the feedback count equals that number at the close, `lock` stays 1 and no pulse is produced.
- R5: While locked, a long window that closes with any other feedback count clears `lock` on the next cycle and pulses `lock_lost` for one cycle. Acquisition then resumes with short windows.
- R6: When `force_unlock` is 1 in a cycle, `lock` is 0 on the next cycle and both counts restart from zero. Ticks in that cycle are ignored. `lock_lost` pulses only if `lock` was 1.
- R7: The feedback count stops one above the current target, so any number of extra feedback ticks, however large, reads as a mismatch and never wraps back to a match.
- R8: `lock_acq` and `lock_lost` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock edge |
| fb_tick | input | 1 | One-cycle pulse per feedback clock edge |
| force_unlock | input | 1 | Drops lock and restarts acquisition |
| lock | output | 1 | Frequency-lock level |
| lock_acq | output | 1 | One-cycle pulse when lock is gained |
| lock_lost | output | 1 | One-cycle pulse when lock is lost |

## Verification
Feedback ticks that arrive together with reference ticks show that acquisition takes exactly one short window and that lock is then held through long windows. Feedback streams with one tick extra or one tick missing separate the tight-mode and relaxed-mode outcomes. One of these drops a single tick in the middle of a long window, which shows that the target switched to the longer count. A feedback tick on every cycle is chosen so that a wrapping counter would land exactly on the target, so only saturation gives the correct mismatch. Random runs of near-matching ticks with occasional forced unlocks then test the ordering of window closes, forced restarts and the event pulses.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;

  typedef enum logic {
    MODE_TIGHT   = 1'b0,
    MODE_RELAXED = 1'b1
  } ld_mode_e;

  // window length in reference ticks for a given mode
  function automatic int unsigned win_target(ld_mode_e mode, int unsigned n, int unsigned k);
    return (mode == MODE_RELAXED) ? (n + k) : n;
  endfunction

  // increment that holds at cap
  function automatic int unsigned sat_inc(int unsigned cnt, logic inc, int unsigned cap);
    if (inc && (cnt < cap)) return cnt + 1;
    return cnt;
  endfunction

endpackage

// File: rtl/pll_ld_ref_window.sv
module pll_ld_ref_window #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          ref_tick,
  input  logic [CW-1:0] target,
  output logic          win_end
);
  logic [CW-1:0] ref_cnt;

  assign win_end = ref_tick && (ref_cnt == (target - CW'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n)                 ref_cnt <= '0;
    else if (clear || win_end)  ref_cnt <= '0;
    else if (ref_tick)          ref_cnt <= ref_cnt + CW'(1);
  end
endmodule

// File: rtl/pll_ld_fb_count.sv
module pll_ld_fb_count
  import pll_ld_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          fb_tick,
  input  logic [CW-1:0] target,
  output logic          fb_match
);
  logic [CW-1:0] fb_cnt;
  logic [CW-1:0] fb_cnt_nx;

  always_comb begin
    fb_cnt_nx = CW'(sat_inc(int'(fb_cnt), fb_tick, int'(target) + 1));
  end

  assign fb_match = (fb_cnt_nx == target);

  always_ff @(posedge clk) begin
    if (!rst_n)      fb_cnt <= '0;
    else if (clear)  fb_cnt <= '0;
    else             fb_cnt <= fb_cnt_nx;
  end
endmodule

// File: rtl/pll_ld_state.sv
module pll_ld_state
  import pll_ld_pkg::*;
#(
  parameter int N_TIGHT = 16,
  parameter int K_EXTRA = 8,
  parameter int CW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_end,
  input  logic          fb_match,
  input  logic          force_unlock,
  output logic          locked,
  output logic          acq_pulse,
  output logic          lost_pulse,
  output logic [CW-1:0] target
);
  ld_mode_e mode;

  assign locked = (mode == MODE_RELAXED);
  assign target = CW'(win_target(mode, N_TIGHT, K_EXTRA));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= MODE_TIGHT;
      acq_pulse  <= 1'b0;
      lost_pulse <= 1'b0;
    end else begin
      acq_pulse  <= 1'b0;
      lost_pulse <= 1'b0;
      if (force_unlock) begin
        lost_pulse <= locked;
        mode       <= MODE_TIGHT;
      end else if (win_end) begin
        acq_pulse  <= fb_match && !locked;
        lost_pulse <= !fb_match && locked;
        mode       <= fb_match ? MODE_RELAXED : MODE_TIGHT;
      end
    end
  end
endmodule

// File: rtl/pll_lock_detector.sv
module pll_lock_detector #(
  parameter int N_TIGHT = 16,
  parameter int K_EXTRA = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic fb_tick,
  input  logic force_unlock,
  output logic lock,
  output logic lock_acq,
  output logic lock_lost
);
  localparam int CW = $clog2(N_TIGHT + K_EXTRA + 2);

  logic [CW-1:0] target;
  logic          win_end;
  logic          fb_match;
  logic          cnt_clear;

  assign cnt_clear = force_unlock || win_end;

  pll_ld_ref_window #(.CW(CW)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (force_unlock),
    .ref_tick (ref_tick),
    .target   (target),
    .win_end  (win_end)
  );

  pll_ld_fb_count #(.CW(CW)) u_fb (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .fb_tick  (fb_tick),
    .target   (target),
    .fb_match (fb_match)
  );

  pll_ld_state #(.N_TIGHT(N_TIGHT), .K_EXTRA(K_EXTRA), .CW(CW)) u_st (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_end      (win_end),
    .fb_match     (fb_match),
    .force_unlock (force_unlock),
    .locked       (lock),
    .acq_pulse    (lock_acq),
    .lost_pulse   (lock_lost),
    .target       (target)
  );
endmodule

// File: rtl/pll_lock_detector_chk.sv
module pll_lock_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic force_unlock,
  input logic lock,
  input logic lock_acq,
  input logic lock_lost,
  input logic win_end,
  input logic fb_match
);
  // R2
  acq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_acq |-> (lock && !$past(lock)));

  // R5
  lost_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |-> (!lock && $past(lock)));

  // R6
  force_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_unlock |=> !lock);

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_acq && lock_lost));

  // R3
  tight_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !fb_match && !lock && !force_unlock) |=> (!lock && !lock_acq && !lock_lost));

  // R4
  relax_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && fb_match && lock && !force_unlock) |=> (lock && !lock_acq && !lock_lost));
endmodule

bind pll_lock_detector pll_lock_detector_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .force_unlock (force_unlock),
  .lock         (lock),
  .lock_acq     (lock_acq),
  .lock_lost    (lock_lost),
  .win_end      (win_end),
  .fb_match     (fb_match)
);

// File: tb/pll_lock_detector_tb.sv
module pll_lock_detector_tb;
  localparam int N = 8;
  localparam int K = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0, fb_tick = 1'b0, force_unlock = 1'b0;
  logic lock, lock_acq, lock_lost;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // bench model state
  int  m_ref = 0, m_fb = 0;
  bit  m_lock = 0, m_acq = 0, m_lost = 0;

  always #10 clk = ~clk;

  pll_lock_detector #(.N_TIGHT(N), .K_EXTRA(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .force_unlock(force_unlock), .lock(lock), .lock_acq(lock_acq), .lock_lost(lock_lost)
  );

  function automatic int win_len(bit locked);
    return locked ? (N + K) : N;
  endfunction

  task automatic model_step(bit r, bit f, bit fu);
    bit hit;
    if (fu) begin
      m_lost = m_lock; m_acq = 0; m_lock = 0; m_ref = 0; m_fb = 0;
    end else if (r && (m_ref + 1 == win_len(m_lock))) begin
      hit = ((m_fb + int'(f)) == win_len(m_lock));
      m_acq = hit && !m_lock; m_lost = !hit && m_lock; m_lock = hit;
      m_ref = 0; m_fb = 0;
    end else begin
      m_ref += int'(r); m_fb += int'(f); m_acq = 0; m_lost = 0;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if ({lock, lock_acq, lock_lost} !== {m_lock, m_acq, m_lost}) begin
      errors++;
      $display("FAIL %s lock/acq/lost actual %b%b%b expected %b%b%b at cycle %0d",
               tag, lock, lock_acq, lock_lost, m_lock, m_acq, m_lost, cycles);
    end
  endtask

  task automatic step(bit r, bit f, bit fu, string tag);
    string t;
    @(negedge clk);
    ref_tick = r; fb_tick = f; force_unlock = fu;
    @(posedge clk);
    model_step(r, f, fu);
    #1;
    if (tag != "") t = tag;
    else if (m_acq) t = "R2";
    else if (m_lost) t = fu ? "R6" : "R5";
    else t = m_lock ? "R4" : "R3";
    compare(t);
    if (lock_acq && lock_lost) begin
      checks++; errors++;
      $display("FAIL R8 acq and lost both 1, expected not both");
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired actual %0d cycles expected < 100000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, "R1");

    // R2: matched ticks acquire lock in one short window
    for (int i = 0; i < 2 * N; i++) step(i % 2 == 1, i % 2 == 1, 0, "");
    // R4: matched ticks keep lock over long windows
    for (int i = 0; i < 3 * (N + K) * 2; i++) step(i % 2 == 1, i % 2 == 1, 0, "");
    // R5: one feedback tick missing in a long window
    for (int i = 0; i < 2 * (N + K); i++) step(i % 2 == 1, (i % 2 == 1) && (i != 5), 0, "");
    // R3: one extra feedback tick in a short window
    for (int i = 0; i < 2 * N; i++) step(i % 2 == 1, (i % 2 == 1) || (i == 4), 0, "");
    for (int i = 0; i < 2 * N; i++) step(i % 2 == 1, (i % 2 == 1) && (i != 3), 0, "");
    // R7: feedback every cycle; a wrapping counter would hit the target
    step(0, 0, 1, "R6");
    for (int i = 0; i < 3 * N * 2; i++) step(i % 3 == 2, 1, 0, "R7");
    // R6: reacquire then force unlock, ticks in that cycle ignored
    step(0, 0, 1, "R6");
    for (int i = 0; i < 2 * N; i++) step(i % 2 == 1, i % 2 == 1, 0, "");
    step(1, 1, 1, "R6");
    step(0, 0, 0, "R6");
    step(0, 0, 1, "R6");
    // random near-matching streams
    for (int i = 0; i < 6000; i++) begin
      bit r = ($urandom % 3) == 0;
      bit f = r ^ (($urandom % 80) == 0);
      bit fu = ($urandom % 700) == 0;
      step(r, f, fu, "");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule